// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 16-bit voltage DAC. A host sends 24-bit words over a three-wire serial link: a frame-select line, a serial clock and a data line. Every pin on that link is sampled by the block's own system clock. The block shifts in each word, decodes a command field and a channel address, and updates a double-buffered pair of registers for each channel. The first register of each pair is a staging code. The second is the code the converter uses, and the block presents it on its outputs.

Each channel has one bit in a transparency mask. A set bit makes that channel's output register follow staging writes in the same frame. A clear bit makes the channel hold until an update command arrives or an external load strobe goes low. Because the two kinds of channel can be mixed, some channels can track writes at once while the others move together on a later load. A separate command turns an internal reference enable flag on or off.

Top module: `quad_dac_frontend`

## Requirements
- R1: After reset, all four output codes are 0, the reference flag is 0 and every transparency bit is 0.
- R2: A word is 24 bits sent MSB first while `sync_n` is low. Bits 23..22 are ignored, bits 21..19 are the command, bits 18..16 are the address and bits 15..0 are the data. The word takes effect on the 24th falling edge of `sclk`. Outputs change on the third rising edge of `clk` after that falling edge, so each `sclk` level must be held for at least 3 `clk` periods.
- R3: Command 000 writes the data into the staging register of each addressed channel. When that channel's transparency bit is 0, its output code does not change.
- R4: Command 001 copies the staging register of each addressed channel into its output code.
- R5: Command 011 writes the data into both the staging register and the output code of each addressed channel.
- R6: Command 010 writes the data into the addressed staging register, then loads all four output codes from their staging registers in the same step.
- R7: Address 000 selects channel A, 001 selects B, 010 selects C, 011 selects D and 111 selects all four. For commands 000 to 011, any other address changes no register.
- R8: Command 110 loads the transparency mask from data bits 3..0 (bit 0 = A, bit 3 = D) and ignores the address. A channel whose bit is 1 takes a command-000 write into its output code at the end of that frame.
- R9: Command 111 sets the reference flag from data bit 0 and ignores the address.
- R10: Commands 100 and 101 change no register.
- R11: If `sync_n` rises before the 24th falling edge of `sclk`, the partial word is discarded and no register changes.
- R12: A falling edge of `ldac_n` loads all four output codes from their staging registers, with the same 3-edge latency as R2. Holding `ldac_n` low does not repeat the load, and neither does its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every serial pin |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe; a falling edge loads all output codes |
| dac_out | output | 64 | Output codes; channel A in bits 15..0, up to channel D in bits 63..48 |
| ref_en | output | 1 | Internal reference enable |

## Verification
The hardest states to reach are those where a staging register holds a value that differs from its output code. Such a state can only be seen indirectly, through a later update command or load strobe. The stimulus therefore writes staging registers with command 000, checks that the outputs hold, and then exposes the staged values through command 001, command 010 or a fall of `ldac_n`. It also writes while `ldac_n` is held low, and sends a word cut short after 23 clocks.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 24;
  localparam logic [2:0] ADDR_ALL = 3'b111;

  typedef enum logic [2:0] {
    CMD_WR_STAGE   = 3'b000,
    CMD_UPD_ONE    = 3'b001,
    CMD_WR_UPD_ALL = 3'b010,
    CMD_WR_UPD_ONE = 3'b011,
    CMD_IGN4       = 3'b100,
    CMD_IGN5       = 3'b101,
    CMD_SET_MASK   = 3'b110,
    CMD_SET_REF    = 3'b111
  } dac_cmd_e;

  typedef struct packed {
    logic [1:0]        spare;
    dac_cmd_e          cmd;
    logic [2:0]        addr;
    logic [DATA_W-1:0] data;
  } dac_word_t;
endpackage

// File: rtl/dacfe_sync.sv
`timescale 1ns/1ps
module dacfe_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] src;
      if (s == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= src;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign q    = stg_q[STAGES-1];
  assign fall = prev_q & ~q;
endmodule

// File: rtl/dacfe_shifter.sv
`timescale 1ns/1ps
module dacfe_shifter
  import dacfe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_fall,
  input  logic      sync_hi,
  input  logic      din,
  output logic      word_vld,
  output dac_word_t word
);
  localparam int CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               shift_en, cnt_en;

  always_comb begin
    shift_en = sclk_fall & ~sync_hi & (cnt_q != CW'(FRAME_W));
    cnt_en   = sync_hi | shift_en;
    sr_d     = {sr_q[FRAME_W-2:0], din};
    cnt_d    = sync_hi ? '0 : cnt_q + CW'(1);
    word_vld = shift_en & (cnt_q == CW'(FRAME_W - 1));
    word     = dac_word_t'(sr_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en) sr_q  <= sr_d;
      if (cnt_en)   cnt_q <= cnt_d;
    end
  end

  // R2: exactly one word per select burst; the counter parks after it
  a_r2_word_parks: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> (cnt_q == CW'(FRAME_W)) && !word_vld);
  // R11: a raised select leaves no partial count behind
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hi |=> (cnt_q == '0));
endmodule

// File: rtl/dacfe_regbank.sv
`timescale 1ns/1ps
module dacfe_regbank
  import dacfe_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_vld,
  input  dac_cmd_e              cmd,
  input  logic [2:0]            addr,
  input  logic [DATA_W-1:0]     data,
  input  logic                  hw_load,
  output logic [NCH*DATA_W-1:0] dac_o,
  output logic                  ref_o
);
  logic [DATA_W-1:0] stg_q [NCH];
  logic [DATA_W-1:0] dac_q [NCH];
  logic [DATA_W-1:0] dac_d [NCH];
  logic [NCH-1:0]    mask_q;
  logic              ref_q;

  logic [NCH-1:0] sel, stg_we, dac_we;
  logic           addr_ok, mask_we, ref_we;

  always_comb begin
    addr_ok = (addr == ADDR_ALL) || (int'(addr) < NCH);
    mask_we = word_vld && (cmd == CMD_SET_MASK);
    ref_we  = word_vld && (cmd == CMD_SET_REF);
    for (int ch = 0; ch < NCH; ch++) begin
      sel[ch]    = addr_ok && ((addr == ADDR_ALL) || (addr == 3'(ch)));
      stg_we[ch] = 1'b0;
      dac_we[ch] = hw_load;
      dac_d[ch]  = stg_q[ch];
      if (word_vld) begin
        unique case (cmd)
          CMD_WR_STAGE: begin
            stg_we[ch] = sel[ch];
            if (sel[ch] && mask_q[ch]) begin
              dac_we[ch] = 1'b1;
              dac_d[ch]  = data;
            end
          end
          CMD_UPD_ONE: begin
            if (sel[ch]) dac_we[ch] = 1'b1;
          end
          CMD_WR_UPD_ALL: begin
            stg_we[ch] = sel[ch];
            if (addr_ok) begin
              dac_we[ch] = 1'b1;
              dac_d[ch]  = sel[ch] ? data : stg_q[ch];
            end
          end
          CMD_WR_UPD_ONE: begin
            stg_we[ch] = sel[ch];
            if (sel[ch]) begin
              dac_we[ch] = 1'b1;
              dac_d[ch]  = data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[ch] <= '0;
          dac_q[ch] <= '0;
        end else begin
          if (stg_we[ch]) stg_q[ch] <= data;
          if (dac_we[ch]) dac_q[ch] <= dac_d[ch];
        end
      end
      assign dac_o[ch*DATA_W +: DATA_W] = dac_q[ch];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ref_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= data[NCH-1:0];
      if (ref_we)  ref_q  <= data[0];
    end
  end

  assign ref_o = ref_q;

  // R9: reference flag moves only on its own command
  a_r9_ref_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && cmd == CMD_SET_REF) |=> $stable(ref_q));
  // R8: mask moves only on its own command
  a_r8_mask_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && cmd == CMD_SET_MASK) |=> $stable(mask_q));
  // R12: outputs hold with no word and no strobe
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_vld && !hw_load) |=> $stable(dac_o));
  // R3: staging write with an all-clear mask leaves outputs untouched
  a_r3_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && cmd == CMD_WR_STAGE && !hw_load && mask_q == '0) |=> $stable(dac_o));
  // R5: write-and-update on channel A lands the data word
  a_r5_wr_upd_a: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && cmd == CMD_WR_UPD_ONE && (addr == 3'b000 || addr == ADDR_ALL))
      |=> (dac_o[DATA_W-1:0] == $past(data)));
endmodule

// File: rtl/quad_dac_frontend.sv
`timescale 1ns/1ps
module quad_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sync_n,
  input  logic                  din,
  input  logic                  ldac_n,
  output logic [NCH*DATA_W-1:0] dac_out,
  output logic                  ref_en
);
  localparam int PIN_DIN  = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SYNC = 2;
  localparam int PIN_LDAC = 3;

  logic [1:0] rst_sq;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  logic [3:0] pin_lvl, pin_fall;
  logic       unused_bits;
  dac_word_t  word;
  logic       word_vld;

  dacfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({ldac_n, sync_n, sclk, din}),
    .q    (pin_lvl),
    .fall (pin_fall)
  );

  assign unused_bits = ^{pin_fall[PIN_DIN], pin_fall[PIN_SYNC], pin_lvl[PIN_LDAC], word.spare};

  dacfe_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sclk_fall(pin_fall[PIN_SCLK]),
    .sync_hi  (pin_lvl[PIN_SYNC]),
    .din      (pin_lvl[PIN_DIN]),
    .word_vld (word_vld),
    .word     (word)
  );

  dacfe_regbank #(.NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .word_vld(word_vld),
    .cmd     (word.cmd),
    .addr    (word.addr),
    .data    (word.data),
    .hw_load (pin_fall[PIN_LDAC]),
    .dac_o   (dac_out),
    .ref_o   (ref_en)
  );
endmodule

// File: tb/tb_quad_dac_frontend.sv
`timescale 1ns/1ps
module tb_quad_dac_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, din = 1'b0, ldac_n = 1'b1;
  logic [63:0] dac_out;
  logic        ref_en;

  always #10 clk = ~clk;

  quad_dac_frontend dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
    .din(din), .ldac_n(ldac_n), .dac_out(dac_out), .ref_en(ref_en)
  );

  logic [15:0] m_stg [4];
  logic [15:0] m_dac [4];
  logic [3:0]  m_mask;
  logic        m_ref;
  int          vectors = 0, miscompares = 0;
  bit          checking = 0, done = 0;
  string       cur_req = "R1";

  always @(negedge clk) begin
    if (checking && !done) begin
      vectors++;
      for (int ch = 0; ch < 4; ch++)
        if (dac_out[ch*16 +: 16] !== m_dac[ch]) begin
          miscompares++;
          $display("FAIL %s ch%0d at %0t: got %h expected %h", cur_req, ch, $time,
                   dac_out[ch*16 +: 16], m_dac[ch]);
        end
      if (ref_en !== m_ref) begin
        miscompares++;
        $display("FAIL %s ref_en at %0t: got %b expected %b", cur_req, $time, ref_en, m_ref);
      end
    end
  end

  task automatic model_word(input logic [2:0] cmd, input logic [2:0] adr, input logic [15:0] dat);
    bit ok = (adr < 4) || (adr == 7);
    for (int ch = 0; ch < 4; ch++) begin
      bit s = ok && ((adr == 7) || (adr == ch));
      case (cmd)
        3'b000: if (s) begin m_stg[ch] = dat; if (m_mask[ch]) m_dac[ch] = dat; end
        3'b001: if (s) m_dac[ch] = m_stg[ch];
        3'b011: if (s) begin m_stg[ch] = dat; m_dac[ch] = dat; end
        3'b010: if (s) m_stg[ch] = dat;
        default: ;
      endcase
    end
    if (cmd == 3'b010 && ok)
      for (int ch = 0; ch < 4; ch++) m_dac[ch] = m_stg[ch];
    if (cmd == 3'b110) m_mask = dat[3:0];
    if (cmd == 3'b111) m_ref = dat[0];
  endtask

  task automatic send(input logic [2:0] cmd, input logic [2:0] adr, input logic [15:0] dat,
                      input int nfall = 24, input logic [1:0] top = 2'b00);
    logic [23:0] w = {top, cmd, adr, dat};
    @(negedge clk) sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nfall; i++) begin
      din = w[23-i];
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (i == 23) begin
        repeat (3) @(posedge clk);
        #1 model_word(cmd, adr, dat);
      end
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe_fall();
    @(negedge clk) ldac_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 for (int ch = 0; ch < 4; ch++) m_dac[ch] = m_stg[ch];
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin m_stg[ch] = '0; m_dac[ch] = '0; end
    m_mask = '0; m_ref = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R1"; checking = 1;
    repeat (4) @(negedge clk);

    cur_req = "R3";  send(3'b000, 3'b000, 16'h1234);
    cur_req = "R2";  send(3'b000, 3'b001, 16'h5678, 24, 2'b11);
    cur_req = "R4";  send(3'b001, 3'b000, 16'hFFFF);
    cur_req = "R4";  send(3'b001, 3'b001, 16'h0000);
    cur_req = "R5";  send(3'b011, 3'b010, 16'hBEEF);
    cur_req = "R7";  send(3'b011, 3'b111, 16'h5555);
    cur_req = "R7";  send(3'b011, 3'b101, 16'h9999);
    cur_req = "R7";  send(3'b010, 3'b100, 16'h8888);
    cur_req = "R6";  send(3'b000, 3'b010, 16'h0101);
    cur_req = "R6";  send(3'b000, 3'b011, 16'h0202);
    cur_req = "R6";  send(3'b010, 3'b001, 16'hAAAA);
    cur_req = "R10"; send(3'b100, 3'b000, 16'h1111);
    cur_req = "R10"; send(3'b101, 3'b111, 16'h2222);
    cur_req = "R8";  send(3'b110, 3'b010, 16'hFFF5);
    cur_req = "R8";  send(3'b000, 3'b111, 16'h7777);
    cur_req = "R8";  send(3'b110, 3'b000, 16'h0000);
    cur_req = "R8";  send(3'b000, 3'b000, 16'h6666);
    cur_req = "R9";  send(3'b111, 3'b011, 16'h0001);
    cur_req = "R9";  send(3'b111, 3'b000, 16'hFFFE);
    cur_req = "R11"; send(3'b011, 3'b000, 16'hDEAD, 23);
    cur_req = "R11"; send(3'b011, 3'b011, 16'hC0DE);
    cur_req = "R12"; send(3'b000, 3'b111, 16'h3333);
    cur_req = "R12"; strobe_fall();
    cur_req = "R12"; send(3'b000, 3'b000, 16'h4444);
    @(negedge clk) ldac_n = 1'b1;
    repeat (8) @(negedge clk);
    cur_req = "R12"; strobe_fall();
    @(negedge clk) ldac_n = 1'b1;
    repeat (8) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule